// File: doc/BRIEF.md
# Digital Potentiometer Command Executor

This block carries out decoded 24-bit commands for the control core of a digital potentiometer. It owns a 9-bit wiper setting (the tap register) and a bank of four 9-bit non-volatile slots. The slots are modelled as flops with a multi-cycle access time. The serial front end delivers one complete command word per `cmd_valid` pulse. Read results come back as a 24-bit response word, which the front end shifts out during its next frame.

The tap register can be set to a value carried in the command, or moved one LSB at a time. A step stops at zero and at full scale and never wraps. Slot commands can read a slot, write a slot directly, store the current tap value into a slot, or load the tap register from a slot. Each slot access keeps `busy_o` high for its whole access time. A command presented while `busy_o` is high is dropped and sets a sticky error flag.

At reset, and on a software restore command, slot 0 is copied into the tap register. Reset also brings the slots back to their programmed image: slot 0 holds `BOOT_TAP` and the other slots hold zero. Holding the write-protect input low blocks every change of slot content. Reads of slots and loads of the tap register from slots still work while write-protect is low.

Top module: `potctl_cmd_exec`

## Requirements
- R1: Reset clears the error flag and the response valid and sets the tap to 0. Reset also raises `busy_o` for `RD_LAT` cycles after release, and in the cycle `busy_o` falls the tap equals slot 0, whose reset content is `BOOT_TAP` (default 0x100).
- R2: Command fields are: opcode = `cmd_word[23:20]`, slot index = `cmd_word[19:18]`, 9-bit value = `cmd_word[8:0]` (bit 8 is the LSB of the first data byte). Opcodes are: 1 read tap, 2 read slot, 3 write slot, 4 load tap from slot, 5 store tap to slot, 6 set tap, 7 step up, 8 step down, 9 software restore.
- R3: A set-tap command accepted at a clock edge makes `tap_o` equal to the command value from the next cycle. It does not raise `busy_o`.
- R4: Step up adds one and step down subtracts one, with the result in the next cycle. Step up at 0x1FF leaves 0x1FF, and step down at 0 leaves 0.
- R5: Read tap raises `rsp_valid_o` for one cycle, in the cycle after acceptance. `rsp_word_o` = {instruction byte `cmd_word[23:16]`, 7 zero bits, 9-bit value}.
- R6: An accepted write-slot command with `wp_n` high holds `busy_o` high for exactly `WR_LAT` cycles (default 16), starting the cycle after acceptance. The slot holds the new value once `busy_o` has fallen.
- R7: Store-tap writes the tap value held at the accepting edge into the selected slot, with the same busy timing as R6.
- R8: Read slot holds `busy_o` high for `RD_LAT` cycles (default 2). In the cycle `busy_o` falls, `rsp_valid_o` is high for one cycle and the word carries the slot content in the R5 layout.
- R9: Load tap from slot uses the R8 timing. In the cycle `busy_o` falls, `tap_o` equals the slot content.
- R10: Software restore uses the R8 timing and loads slot 0 into the tap, whatever slot index the command carries.
- R11: With `wp_n` low, write-slot and store-tap commands are ignored: no busy, no slot change, no error. Read slot and load tap still work.
- R12: A command presented while `busy_o` is high is dropped, including in the last busy cycle. It sets `err_o` in the next cycle, and `err_o` stays high until reset.
- R13: Opcodes 0 and 10 to 15 change nothing: no busy, no response, tap unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle strobe marking a complete command word |
| cmd_word | input | 24 | Decoded command: instruction byte and two data bytes |
| wp_n | input | 1 | Active-low write protect for slot content |
| tap_o | output | 9 | Current tap register value |
| busy_o | output | 1 | Slot access in progress; commands are not accepted |
| err_o | output | 1 | Sticky flag: a command arrived while busy |
| rsp_valid_o | output | 1 | One-cycle strobe marking a new response word |
| rsp_word_o | output | 24 | Response word for the next outgoing frame |

## Verification
The completion of a slot access and the arrival of a new command can meet at the same clock edge. The bench provokes this by presenting a set-tap command in the last cycle in which `busy_o` is still high, right after a slot write. The command must be dropped and `err_o` must rise. The tap must keep its old value, and a read of the written slot must still return the new data, which shows that the completing write was not disturbed. A second, earlier collision in the first busy cycle checks the same drop-and-flag rule away from the boundary.

// File: rtl/potctl_pkg.sv
package potctl_pkg;

   localparam int unsigned OPC_W  = 4;
   localparam int unsigned INSN_W = 8;

   typedef enum logic [OPC_W-1:0] {
      OPC_NOP      = 4'd0,
      OPC_RD_TAP   = 4'd1,
      OPC_RD_SLOT  = 4'd2,
      OPC_WR_SLOT  = 4'd3,
      OPC_LD_TAP   = 4'd4,
      OPC_ST_TAP   = 4'd5,
      OPC_SET_TAP  = 4'd6,
      OPC_STEP_UP  = 4'd7,
      OPC_STEP_DN  = 4'd8,
      OPC_RESTORE  = 4'd9
   } potctl_opc_e;

   // one-hot style action flags produced by the decoder
   typedef struct packed {
      logic rd_tap;
      logic rd_slot;
      logic wr_slot;
      logic ld_tap;
      logic st_tap;
      logic set_tap;
      logic step_up;
      logic step_dn;
      logic restore;
   } potctl_act_t;

endpackage

// File: rtl/potctl_decode.sv
module potctl_decode
   import potctl_pkg::*;
#(
   parameter int unsigned CMD_W   = 24,
   parameter int unsigned TAP_W   = 9,
   parameter int unsigned SLOT_AW = 2
) (
   input  logic [CMD_W-1:0]   cmd_word,
   output potctl_act_t        act_o,
   output logic [SLOT_AW-1:0] slot_o,
   output logic [TAP_W-1:0]   value_o,
   output logic [INSN_W-1:0]  insn_o
);

   localparam int unsigned OPC_MSB  = CMD_W - 1;
   localparam int unsigned SLOT_MSB = CMD_W - 1 - OPC_W;

   logic [OPC_W-1:0] opc;

   assign opc     = cmd_word[OPC_MSB -: OPC_W];
   assign slot_o  = cmd_word[SLOT_MSB -: SLOT_AW];
   assign value_o = cmd_word[TAP_W-1:0];
   assign insn_o  = cmd_word[OPC_MSB -: INSN_W];

   always_comb begin
      act_o = '0;
      case (opc)
         OPC_RD_TAP:  act_o.rd_tap  = 1'b1;
         OPC_RD_SLOT: act_o.rd_slot = 1'b1;
         OPC_WR_SLOT: act_o.wr_slot = 1'b1;
         OPC_LD_TAP:  act_o.ld_tap  = 1'b1;
         OPC_ST_TAP:  act_o.st_tap  = 1'b1;
         OPC_SET_TAP: act_o.set_tap = 1'b1;
         OPC_STEP_UP: act_o.step_up = 1'b1;
         OPC_STEP_DN: act_o.step_dn = 1'b1;
         OPC_RESTORE: act_o.restore = 1'b1;
         default:     act_o = '0;
      endcase
   end

endmodule

// File: rtl/potctl_tap_reg.sv
module potctl_tap_reg #(
   parameter int unsigned TAP_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [TAP_W-1:0] load_val,
   input  logic             up_en,
   input  logic             dn_en,
   output logic [TAP_W-1:0] tap_o
);

   localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};
   localparam logic [TAP_W-1:0] TAP_MIN = '0;

   logic [TAP_W-1:0] tap_q;
   logic [TAP_W-1:0] tap_d;
   logic             at_top;
   logic             at_bot;

   assign at_top = (tap_q == TAP_MAX);
   assign at_bot = (tap_q == TAP_MIN);

   // load has priority; steps stop at the rails
   always_comb begin
      tap_d = tap_q;
      if (load_en)
         tap_d = load_val;
      else if (up_en && !at_top)
         tap_d = tap_q + 1'b1;
      else if (dn_en && !at_bot)
         tap_d = tap_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tap_q <= '0;
      else
         tap_q <= tap_d;
   end

   assign tap_o = tap_q;

endmodule

// File: rtl/potctl_slot_bank.sv
module potctl_slot_bank #(
   parameter int unsigned      TAP_W    = 9,
   parameter int unsigned      SLOT_AW  = 2,
   parameter int unsigned      RD_LAT   = 2,
   parameter int unsigned      WR_LAT   = 16,
   parameter logic [TAP_W-1:0] BOOT_TAP = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_rd,
   input  logic               start_wr,
   input  logic [SLOT_AW-1:0] addr,
   input  logic [TAP_W-1:0]   wdata,
   output logic               busy_o,
   output logic               fire_rd_o,
   output logic [TAP_W-1:0]   rd_data_o
);

   localparam int unsigned NSLOT   = 1 << SLOT_AW;
   localparam int unsigned LAT_MAX = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
   localparam int unsigned CNT_W   = $clog2(LAT_MAX + 1);
   localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_LAT - 1);
   localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_LAT - 1);

   logic               busy_q;
   logic               is_wr_q;
   logic [SLOT_AW-1:0] addr_q;
   logic [TAP_W-1:0]   wdata_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               last_cyc;
   logic               commit_wr;
   logic [TAP_W-1:0]   slot_rd [NSLOT];

   assign last_cyc  = busy_q && (cnt_q == '0);
   assign commit_wr = last_cyc && is_wr_q;

   // access sequencer; reset leaves a read of slot 0 in flight (boot restore)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b1;
         is_wr_q <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         cnt_q   <= RD_LOAD;
      end else if (busy_q) begin
         if (cnt_q == '0)
            busy_q <= 1'b0;
         else
            cnt_q <= cnt_q - 1'b1;
      end else if (start_rd || start_wr) begin
         busy_q  <= 1'b1;
         is_wr_q <= start_wr;
         addr_q  <= addr;
         wdata_q <= wdata;
         cnt_q   <= start_wr ? WR_LOAD : RD_LOAD;
      end
   end

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      logic [TAP_W-1:0] cell_q;
      logic             hit;
      logic [TAP_W-1:0] img;

      assign hit = commit_wr && (addr_q == SLOT_AW'(i));

      if (i == 0) begin : g_boot
         assign img = BOOT_TAP;
      end else begin : g_blank
         assign img = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q <= img;
         else if (hit)
            cell_q <= wdata_q;
      end

      assign slot_rd[i] = cell_q;
   end

   assign busy_o    = busy_q;
   assign fire_rd_o = last_cyc && !is_wr_q;
   assign rd_data_o = slot_rd[addr_q];

endmodule

// File: rtl/potctl_cmd_exec.sv
module potctl_cmd_exec
   import potctl_pkg::*;
#(
   parameter int unsigned      CMD_W    = 24,
   parameter int unsigned      TAP_W    = 9,
   parameter int unsigned      SLOT_AW  = 2,
   parameter int unsigned      RD_LAT   = 2,
   parameter int unsigned      WR_LAT   = 16,
   parameter logic [TAP_W-1:0] BOOT_TAP = 9'h100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [CMD_W-1:0] cmd_word,
   input  logic             wp_n,
   output logic [TAP_W-1:0] tap_o,
   output logic             busy_o,
   output logic             err_o,
   output logic             rsp_valid_o,
   output logic [CMD_W-1:0] rsp_word_o
);

   localparam int unsigned PAD_W = CMD_W - INSN_W - TAP_W;

   // elaboration-time parameter checks
   if (CMD_W < 16) begin : g_chk_cmd
      $error("CMD_W must hold an instruction byte and a data field");
   end
   if (TAP_W + INSN_W >= CMD_W) begin : g_chk_tap
      $error("TAP_W does not fit below the instruction byte");
   end
   if (SLOT_AW < 1 || SLOT_AW > INSN_W - OPC_W) begin : g_chk_slot
      $error("SLOT_AW must fit in the low nibble of the instruction byte");
   end
   if (RD_LAT < 1 || WR_LAT < 1) begin : g_chk_lat
      $error("access latencies must be at least one cycle");
   end

   potctl_act_t        act;
   logic [SLOT_AW-1:0] slot_sel;
   logic [TAP_W-1:0]   cmd_val;
   logic [INSN_W-1:0]  insn;
   logic               accept;
   logic               start_rd;
   logic               start_wr;
   logic               bank_busy;
   logic               fire_rd;
   logic [TAP_W-1:0]   slot_data;
   logic [TAP_W-1:0]   tap_cur;
   logic               tap_load;
   logic [TAP_W-1:0]   tap_load_val;
   logic               pend_ld_q;
   logic               pend_rsp_q;
   logic [INSN_W-1:0]  pend_insn_q;
   logic               err_q;
   logic               rsp_valid_q;
   logic [CMD_W-1:0]   rsp_word_q;
   logic               rsp_now;
   logic [TAP_W-1:0]   rsp_val;
   logic [INSN_W-1:0]  rsp_insn;

   potctl_decode #(
      .CMD_W   (CMD_W),
      .TAP_W   (TAP_W),
      .SLOT_AW (SLOT_AW)
   ) dec_i (
      .cmd_word (cmd_word),
      .act_o    (act),
      .slot_o   (slot_sel),
      .value_o  (cmd_val),
      .insn_o   (insn)
   );

   assign accept   = cmd_valid && !bank_busy;
   assign start_wr = accept && wp_n && (act.wr_slot || act.st_tap);
   assign start_rd = accept && (act.rd_slot || act.ld_tap || act.restore);

   potctl_slot_bank #(
      .TAP_W    (TAP_W),
      .SLOT_AW  (SLOT_AW),
      .RD_LAT   (RD_LAT),
      .WR_LAT   (WR_LAT),
      .BOOT_TAP (BOOT_TAP)
   ) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_rd  (start_rd),
      .start_wr  (start_wr),
      .addr      (act.restore ? '0 : slot_sel),
      .wdata     (act.st_tap ? tap_cur : cmd_val),
      .busy_o    (bank_busy),
      .fire_rd_o (fire_rd),
      .rd_data_o (slot_data)
   );

   // purpose of the read in flight; reset implies the boot restore
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_ld_q   <= 1'b1;
         pend_rsp_q  <= 1'b0;
         pend_insn_q <= '0;
      end else if (start_rd) begin
         pend_ld_q   <= act.ld_tap || act.restore;
         pend_rsp_q  <= act.rd_slot;
         pend_insn_q <= insn;
      end
   end

   assign tap_load     = (accept && act.set_tap) || (fire_rd && pend_ld_q);
   assign tap_load_val = fire_rd ? slot_data : cmd_val;

   potctl_tap_reg #(
      .TAP_W (TAP_W)
   ) tap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (tap_load),
      .load_val (tap_load_val),
      .up_en    (accept && act.step_up),
      .dn_en    (accept && act.step_dn),
      .tap_o    (tap_cur)
   );

   assign rsp_now  = (accept && act.rd_tap) || (fire_rd && pend_rsp_q);
   assign rsp_val  = fire_rd ? slot_data : tap_cur;
   assign rsp_insn = fire_rd ? pend_insn_q : insn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_word_q  <= '0;
         err_q       <= 1'b0;
      end else begin
         rsp_valid_q <= rsp_now;
         if (rsp_now)
            rsp_word_q <= {rsp_insn, {PAD_W{1'b0}}, rsp_val};
         if (cmd_valid && bank_busy)
            err_q <= 1'b1;
      end
   end

   assign tap_o       = tap_cur;
   assign busy_o      = bank_busy;
   assign err_o       = err_q;
   assign rsp_valid_o = rsp_valid_q;
   assign rsp_word_o  = rsp_word_q;

endmodule

// File: rtl/potctl_cmd_exec_chk.sv
module potctl_cmd_exec_chk #(
   parameter int unsigned CMD_W  = 24,
   parameter int unsigned TAP_W  = 9,
   parameter int unsigned WR_LAT = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [CMD_W-1:0] cmd_word,
   input logic             wp_n,
   input logic [TAP_W-1:0] tap_o,
   input logic             busy_o,
   input logic             err_o,
   input logic             rsp_valid_o,
   input logic [CMD_W-1:0] rsp_word_o
);

   localparam logic [TAP_W-1:0] TOP = {TAP_W{1'b1}};

   logic [3:0]  opc;
   logic        go;
   logic [31:0] run_q;

   assign opc = cmd_word[CMD_W-1 -: 4];
   assign go  = cmd_valid && !busy_o;

   // length of the current busy run, for the window check
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (busy_o)
         run_q <= run_q + 1;
      else
         run_q <= '0;
   end

   // R12
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && busy_o |=> err_o);

   // R12
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   // R3
   set_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go && opc == 4'd6 |=> tap_o == $past(cmd_word[TAP_W-1:0]));

   // R4
   step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go && opc == 4'd7 && tap_o != TOP |=> tap_o == TAP_W'($past(tap_o) + 1'b1));

   // R4
   up_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go && opc == 4'd7 && tap_o == TOP |=> tap_o == TOP);

   // R4
   dn_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go && opc == 4'd8 && tap_o == '0 |=> tap_o == '0);

   // R11
   wp_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go && !wp_n && (opc == 4'd3 || opc == 4'd5) |=> !busy_o);

   // R6
   wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go && wp_n && (opc == 4'd3 || opc == 4'd5) |=> busy_o);

   // R6
   busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= WR_LAT);

   // R5
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |-> !busy_o);

   // R13
   nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go && (opc == 4'd0 || opc > 4'd9) |=> !busy_o && !rsp_valid_o && $stable(tap_o));

endmodule

bind potctl_cmd_exec potctl_cmd_exec_chk #(
   .CMD_W  (CMD_W),
   .TAP_W  (TAP_W),
   .WR_LAT (WR_LAT)
) chk_i (.*);

// File: tb/potctl_cmd_exec_tb_top.sv
module potctl_cmd_exec_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int RD_LAT     = 2;
   localparam int WR_LAT     = 16;
   localparam int WATCHDOG   = 20000;

   typedef struct packed {
      logic [23:0] cmd;
      logic        wp;
      logic [8:0]  tap;
      logic        rsp;
      logic [8:0]  val;
      logic [4:0]  nbusy;
   } vec_t;

   localparam int NV = 24;
   // fields: cmd, wp_n, expected tap, response expected, response value, busy cycles
   localparam vec_t VECS [NV] = '{
      '{24'h100000, 1'b1, 9'h100, 1'b1, 9'h100, 5'd0},   // R5 read tap after boot
      '{24'h6001FE, 1'b1, 9'h1FE, 1'b0, 9'h000, 5'd0},   // R3 R2 set, bit 8 from first data byte
      '{24'h700000, 1'b1, 9'h1FF, 1'b0, 9'h000, 5'd0},   // R4 up
      '{24'h700000, 1'b1, 9'h1FF, 1'b0, 9'h000, 5'd0},   // R4 up saturates
      '{24'h600001, 1'b1, 9'h001, 1'b0, 9'h000, 5'd0},   // R3
      '{24'h800000, 1'b1, 9'h000, 1'b0, 9'h000, 5'd0},   // R4 down
      '{24'h800000, 1'b1, 9'h000, 1'b0, 9'h000, 5'd0},   // R4 down saturates
      '{24'hF00000, 1'b1, 9'h000, 1'b0, 9'h000, 5'd0},   // R13 opcode 15
      '{24'h3800AA, 1'b1, 9'h000, 1'b0, 9'h000, 5'd16},  // R6 write slot 2
      '{24'h280000, 1'b1, 9'h000, 1'b1, 9'h0AA, 5'd2},   // R8 read slot 2
      '{24'h380155, 1'b0, 9'h000, 1'b0, 9'h000, 5'd0},   // R11 protected write
      '{24'h280000, 1'b0, 9'h000, 1'b1, 9'h0AA, 5'd2},   // R11 read under protect
      '{24'h480000, 1'b0, 9'h0AA, 1'b0, 9'h000, 5'd2},   // R9 R11 load under protect
      '{24'h600123, 1'b1, 9'h123, 1'b0, 9'h000, 5'd0},   // R3
      '{24'h540000, 1'b0, 9'h123, 1'b0, 9'h000, 5'd0},   // R11 protected store
      '{24'h240000, 1'b1, 9'h123, 1'b1, 9'h000, 5'd2},   // R11 slot 1 untouched
      '{24'h540000, 1'b1, 9'h123, 1'b0, 9'h000, 5'd16},  // R7 store tap to slot 1
      '{24'h600042, 1'b1, 9'h042, 1'b0, 9'h000, 5'd0},   // R3
      '{24'h240000, 1'b1, 9'h042, 1'b1, 9'h123, 5'd2},   // R7 stored value captured
      '{24'h300077, 1'b1, 9'h042, 1'b0, 9'h000, 5'd16},  // R6 write slot 0
      '{24'h6001AB, 1'b1, 9'h1AB, 1'b0, 9'h000, 5'd0},   // R3
      '{24'h9C0000, 1'b1, 9'h077, 1'b0, 9'h000, 5'd2},   // R10 restore ignores slot 3 field
      '{24'h100000, 1'b1, 9'h077, 1'b1, 9'h077, 5'd0},   // R5
      '{24'hA00000, 1'b1, 9'h077, 1'b0, 9'h000, 5'd0}    // R13 opcode 10
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_valid;
   logic [23:0] cmd_word;
   logic        wp_n;
   logic [8:0]  tap_o;
   logic        busy_o;
   logic        err_o;
   logic        rsp_valid_o;
   logic [23:0] rsp_word_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   potctl_cmd_exec #(
      .RD_LAT (RD_LAT),
      .WR_LAT (WR_LAT)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .cmd_word    (cmd_word),
      .wp_n        (wp_n),
      .tap_o       (tap_o),
      .busy_o      (busy_o),
      .err_o       (err_o),
      .rsp_valid_o (rsp_valid_o),
      .rsp_word_o  (rsp_word_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // present one command at the current negedge; returns at the next negedge
   task automatic send(input logic [23:0] c, input logic w);
      cmd_word  = c;
      wp_n      = w;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy_o && n < 200) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      rst_n     = 1'b0;
      cmd_valid = 1'b0;
      cmd_word  = '0;
      wp_n      = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 tap in reset", 32'(tap_o), 32'h0);
      check("R1 busy in reset", 32'(busy_o), 32'h1);
      check("R1 err in reset", 32'(err_o), 32'h0);
      check("R1 rsp in reset", 32'(rsp_valid_o), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      wait_idle(n);
      check("R1 boot busy cycles", 32'(n + 1), 32'(RD_LAT));
      check("R1 boot restore", 32'(tap_o), 32'h100);

      // vector walk
      for (int i = 0; i < NV; i++) begin
         send(VECS[i].cmd, VECS[i].wp);
         wait_idle(n);
         check($sformatf("R2 vec %0d busy", i), 32'(n), 32'(VECS[i].nbusy));
         check($sformatf("R2 vec %0d tap", i), 32'(tap_o), 32'(VECS[i].tap));
         check($sformatf("R2 vec %0d rsp_valid", i), 32'(rsp_valid_o), 32'(VECS[i].rsp));
         if (VECS[i].rsp)
            check($sformatf("R2 vec %0d rsp_word", i), 32'(rsp_word_o),
                  32'({VECS[i].cmd[23:16], 7'b0, VECS[i].val}));
         check($sformatf("R12 vec %0d no error", i), 32'(err_o), 32'h0);
      end

      // R12 collision in first busy cycle
      send(24'h6000F0, 1'b1);
      send(24'h3C01C3, 1'b1);
      check("R12 busy after write", 32'(busy_o), 32'h1);
      send(24'h600011, 1'b1);
      check("R12 err after drop", 32'(err_o), 32'h1);
      check("R12 tap kept", 32'(tap_o), 32'h0F0);
      // R12 collision in last busy cycle
      repeat (WR_LAT - 2) @(negedge clk);
      check("R12 still busy last cycle", 32'(busy_o), 32'h1);
      send(24'h600022, 1'b1);
      check("R12 idle after completion", 32'(busy_o), 32'h0);
      check("R12 tap kept at completion", 32'(tap_o), 32'h0F0);
      send(24'h2C0000, 1'b1);
      wait_idle(n);
      check("R6 write committed despite drop", 32'(rsp_word_o), 32'h2C01C3);
      send(24'h600033, 1'b1);
      check("R12 later command works", 32'(tap_o), 32'h033);
      check("R12 err sticky", 32'(err_o), 32'h1);

      // R1 reset clears error and restores slot image
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 err cleared", 32'(err_o), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      wait_idle(n);
      check("R1 restore after second reset", 32'(tap_o), 32'h100);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule